// File: doc/BRIEF.md
# Serial Register Bank Target

This block is the target end of a simple serial link that configures a chip. It holds nine 16-bit configuration registers and presents all of them in parallel on `cfg`. A host reaches the block over four wires. An active-low enable marks the frame. Data on the input wire is taken on rising edges of the serial clock. A separate output wire returns read data. Every frame begins with a 24-bit word. That word names the chip, names one register and carries 16 bits of payload.

The serial pins are sampled in the system clock domain. Each one goes through a two-stage synchronizer, and edges are found by comparing a delayed copy. The write into a register waits until the enable line is released, and it only happens if exactly 24 bits arrived. A frame is dropped if its chip field differs from the `chip_id` strap or if its register number is out of range. Reads are indirect. The host starts a frame that writes register 7 with the number of the register it wants. It then keeps clocking for 24 more cycles, and the selected register comes back on `sdo` during those cycles.

Top module: `serial_regbank`

## Requirements
- R1: While `rst_n` is low, and directly after it, all nine registers read as zero on `cfg` and `sdo` is low. A reset in the middle of operation clears registers that were written before it.
- R2: A frame is 24 bits and each field is sent least significant bit first. The assembled word holds the chip field in bits 2:0, the register number in bits 7:3 and the payload in bits 23:8. A valid frame writes the payload into the named register only, and register k appears on `cfg[16k+15:16k]`.
- R3: The payload is not written while enable is still low after the 24th clock. It becomes visible only after enable returns high.
- R4: A frame whose chip field differs from `chip_id` changes no register and returns no read data.
- R5: A frame whose register number is 9 or greater changes no register.
- R6: A frame that ends after any number of clocks other than 24 changes no register. 23 and 25 clocks are the tested cases. The one exception is the read frame of R7.
- R7: A read frame lasts 48 clocks. Its first 24 bits write register 7 with the target register number in the low 5 payload bits. After rising clock 25+j, `sdo` carries bit j of the target register for j = 0..15, and it carries 0 after clocks 41 to 48.
- R8: When a read frame ends after its 48th clock, register 7 holds the pointer payload. A plain 24-bit write to register 7 also stores its payload.
- R9: `sdo` stays low when enable is high, during write frames, and during the first 24 clocks of a read frame.
- R10: A read whose pointer names register 9 or above returns 24 zero bits on `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 3 | Strapped address compared with the chip field |
| sen_n | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data out |
| cfg | output | 144 | All nine registers, register k in bits 16k+15:16k |

## Verification
The assertions run on every cycle and check three things. Register contents change only on the cycle after enable is released, and never when that frame carried a foreign chip field or an out-of-range register number. `sdo` stays low whenever no read is active. A read is never active before 24 bits have been taken. Some behaviour can only be shown by the bench scenarios. These are the exact bit ordering of fields, the frame-length rule at 23 and 25 clocks, the position of each returned bit among the 48 clocks, pointer values beyond the bank, and the effect of a reset in mid-run.

// File: rtl/serial_regbank.sv
module serial_regbank #(
  parameter int NREG    = 9,
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int RW      = 5,
  parameter int PTR_REG = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        chip_id,
  input  logic                 sen_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic [NREG*DW-1:0]   cfg
);

  localparam int FW  = AW + RW + DW;
  localparam int RDW = 2 * FW;
  localparam int CW  = $clog2(RDW + 2);
  localparam logic [CW-1:0] FW_C   = CW'(FW);
  localparam logic [CW-1:0] LAST_C = CW'(FW - 1);
  localparam logic [CW-1:0] RDW_C  = CW'(RDW);
  localparam logic [RW-1:0] NREG_R = RW'(NREG);
  localparam logic [RW-1:0] PTR_R  = RW'(PTR_REG);

  logic [2:0]    sclk_p, sen_p;
  logic [1:0]    sdi_p;
  logic [FW-1:0] sh, osh, nxt;
  logic [CW-1:0] cnt;
  logic          rd_act;
  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] rd_word;

  wire active    = ~sen_p[1];
  wire sclk_rise = sclk_p[1] & ~sclk_p[2];
  wire sen_fall  = ~sen_p[1] & sen_p[2];
  wire sen_rise  = sen_p[1] & ~sen_p[2];

  assign nxt = {sdi_p[1], sh[FW-1:1]};

  wire [AW-1:0] f_addr = sh[AW-1:0];
  wire [RW-1:0] f_reg  = sh[AW+RW-1:AW];
  wire [DW-1:0] f_dat  = sh[FW-1:AW+RW];
  wire [AW-1:0] n_addr = nxt[AW-1:0];
  wire [RW-1:0] n_reg  = nxt[AW+RW-1:AW];
  wire [RW-1:0] n_ptr  = nxt[AW+RW+RW-1:AW+RW];

  wire len_ok   = (cnt == FW_C) || (rd_act && cnt == RDW_C);
  wire commit   = sen_rise && (f_addr == chip_id) && (f_reg < NREG_R) && len_ok;
  wire rd_start = (cnt == LAST_C) && (n_addr == chip_id) && (n_reg == PTR_R);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (n_ptr == RW'(i)) rd_word = bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sen_p  <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sen_p  <= {sen_p[1:0], sen_n};
      sdi_p  <= {sdi_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      osh    <= '0;
      cnt    <= '0;
      rd_act <= 1'b0;
    end else if (sen_fall) begin
      cnt    <= '0;
      rd_act <= 1'b0;
    end else if (active && sclk_rise) begin
      if (cnt < FW_C)   sh  <= nxt;
      if (cnt <= RDW_C) cnt <= cnt + 1'b1;
      if (rd_start) begin
        rd_act <= 1'b1;
        osh    <= {{(FW-DW){1'b0}}, rd_word};
      end else if (rd_act) begin
        osh <= osh >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sdo <= 1'b0;
    else if (!active)    sdo <= 1'b0;
    else if (sclk_rise)  sdo <= rd_act && (cnt >= FW_C) && (cnt < RDW_C) && osh[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < NREG; i++)
        if (f_reg == RW'(i)) bank[i] <= f_dat;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg[g*DW +: DW] = bank[g];
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sen_rise) |-> $stable(cfg));

  // R4
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sen_rise && (f_addr != chip_id)) |-> $stable(cfg));

  // R5
  bad_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sen_rise && (f_reg >= NREG_R)) |-> $stable(cfg));

  // R9
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_act) |-> !sdo);

  // R7
  read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> (cnt >= FW_C));

endmodule

// File: tb/test_serial_regbank.sv
module test_serial_regbank;
  localparam int NREG = 9;
  localparam int DW = 16;
  localparam logic [2:0] STRAP = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, sen_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [NREG*DW-1:0] cfg;
  logic [DW-1:0] model [NREG];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_regbank i_serial_regbank (
    .clk(clk), .rst_n(rst_n), .chip_id(STRAP), .sen_n(sen_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .cfg(cfg)
  );

  // {chip[2:0], reg[4:0], data[15:0], clocks[5:0]}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {3'd5, 5'd0,  16'hA5C3, 6'd24},
    {3'd5, 5'd8,  16'h1234, 6'd24},
    {3'd5, 5'd3,  16'hFFFF, 6'd24},
    {3'd2, 5'd3,  16'h0000, 6'd24},
    {3'd5, 5'd9,  16'hBEEF, 6'd24},
    {3'd5, 5'd31, 16'h0101, 6'd24},
    {3'd5, 5'd3,  16'h0F0F, 6'd23},
    {3'd5, 5'd3,  16'h0F0F, 6'd25},
    {3'd5, 5'd1,  16'h8001, 6'd24},
    {3'd5, 5'd7,  16'h0002, 6'd24}
  };

  function automatic logic [NREG*DW-1:0] packed_model();
    logic [NREG*DW-1:0] p;
    for (int i = 0; i < NREG; i++) p[i*DW +: DW] = model[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o);
    sdi = b;
    repeat (5) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    o = sdo;
    @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic open_frame();
    @(negedge clk);
    sen_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (3) @(negedge clk);
    sen_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic shift(input logic [47:0] w, input int n, output logic [47:0] seen);
    seen = '0;
    for (int i = 0; i < n; i++) bit_io(w[i], seen[i]);
  endtask

  task automatic frame(input logic [47:0] w, input int n, output logic [47:0] seen);
    open_frame();
    shift(w, n, seen);
    close_frame();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  task automatic read_reg(input logic [2:0] chip, input logic [4:0] ptr, output logic [47:0] seen);
    frame({24'b0, 11'b0, ptr, 5'd7, chip}, 48, seen);
  endtask

  initial begin
    logic [47:0] seen;
    logic [15:0] exp_rd;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(cfg == '0 && sdo == 1'b0, "R1 registers and sdo under reset", {sdo, cfg}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg == '0 && sdo == 1'b0, "R1 registers and sdo after reset", {sdo, cfg}, '0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] a = VEC[v][29:27];
      logic [4:0] r = VEC[v][26:22];
      logic [15:0] d = VEC[v][21:6];
      int n = int'(VEC[v][5:0]);
      frame({24'b0, d, r, a}, n, seen);
      if (n == 24 && a == STRAP && r < 5'd9) model[r] = d;
      chk(cfg == packed_model(), "R2 R4 R5 R6 R8 bank after vector", 144'(cfg), 144'(packed_model()));
      chk(seen == '0, "R9 sdo low during write vector", 144'(seen), '0);
    end

    // R3: payload held back until enable rises
    open_frame();
    shift({24'b0, 16'h7777, 5'd2, STRAP}, 24, seen);
    repeat (12) @(negedge clk);
    chk(cfg == packed_model(), "R3 no write while enable low", 144'(cfg), 144'(packed_model()));
    close_frame();
    model[2] = 16'h7777;
    chk(cfg == packed_model(), "R3 write after enable rise", 144'(cfg), 144'(packed_model()));

    // R7: reads of several registers
    for (int p = 0; p < 4; p++) begin
      logic [4:0] ptr = (p == 0) ? 5'd0 : (p == 1) ? 5'd8 : (p == 2) ? 5'd3 : 5'd2;
      exp_rd = model[ptr];
      read_reg(STRAP, ptr, seen);
      chk(seen == {8'b0, exp_rd, 24'b0}, "R7 R9 read frame sdo bits", 144'(seen), 144'({8'b0, exp_rd, 24'b0}));
      model[7] = {11'b0, ptr};
      chk(cfg == packed_model(), "R8 pointer stored in register 7", 144'(cfg), 144'(packed_model()));
    end

    // R10: pointer beyond bank
    read_reg(STRAP, 5'd12, seen);
    chk(seen == '0, "R10 out-of-range pointer reads zero", 144'(seen), '0);
    model[7] = 16'd12;
    chk(cfg == packed_model(), "R8 out-of-range pointer stored", 144'(cfg), 144'(packed_model()));

    // R4: read with foreign chip field
    read_reg(3'd1, 5'd0, seen);
    chk(seen == '0, "R4 foreign read gives no data", 144'(seen), '0);
    chk(cfg == packed_model(), "R4 foreign read changes nothing", 144'(cfg), 144'(packed_model()));

    repeat (4) @(negedge clk);
    chk(sdo == 1'b0, "R9 sdo low when idle", 144'(sdo), '0);

    // R1: reset in mid-run
    do_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg == '0, "R1 mid-run reset clears bank", 144'(cfg), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule